// File: doc/BRIEF.md
# Indexed block register slave on a two-wire serial bus

This block is a slave on an SMBus-style two-wire bus. It gives a host indexed access to a file of 32 eight-bit control registers. The host addresses the slave with the write address D2h or the read address D3h, names a starting register offset, and then moves a run of bytes. The offset advances after every data byte and wraps inside the register space. A single-byte access is a block access of length one, or a read that the host stops after the first data byte.

In a write, the host sends a byte count after the offset. The slave then accepts exactly that many data bytes. In a read, the host sends the offset in a write phase, issues a repeated start and the read address, and the slave answers with a byte count and then the data. The host acknowledges each byte it wants to continue, and ends the read with a not-acknowledge and a stop, early if it likes.

The bus lines are sampled on the system clock through two-flop synchronisers. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. The slave only ever pulls SDA low through `sda_oe`. The whole register file is presented in parallel on `cfg_q`. Register 7 is a fixed identity byte. Bits 2:0 of register 6 mirror the `sel_in` pins.

Top module: `smbus_index_slave`

## Requirements
- R1: The slave acknowledges an address byte of D2h (write) or D3h (read). Any other address byte gets no acknowledge, and SDA stays released (`sda_oe`=0) until the next START.
- R2: A write frame (D2h, offset, count N, N data bytes) acknowledges every byte. It stores data byte k at register (offset+k), visible on `cfg_q` bits [8*r+7:8*r] for register r.
- R3: A write count of 0 is not acknowledged, and the frame changes no register and no count.
- R4: Data bytes after the N-th in a write frame are not acknowledged and are not stored.
- R5: A read frame (D2h, offset, repeated START, D3h) returns a count byte first, then the register contents from the offset upward, most significant bit first.
- R6: The count byte sent in a read is 8 after reset. After that it equals the count N of the most recent acknowledged write count.
- R7: A not-acknowledge from the host ends the read at any byte. The slave releases SDA, and the next frame works normally.
- R8: The register offset advances by one after each data byte and wraps from 31 to 0.
- R9: Register 7 always reads the identity value 15h. Bits 2:0 of register 6 always read `sel_in`. Writes to those bits are ignored, while bits 7:3 of register 6 are writable.
- R10: After reset every writable register bit is 0 and SDA is released.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_in | input | 3 | Latched selection bits shown in register 6 bits 2:0 |
| cfg_q | output | 256 | All 32 registers, register r on bits [8*r+7:8*r] |

## Verification
A wrong byte role or bit counter shows up at the ports within one byte time. It appears as a missing or misplaced acknowledge, or as a count byte that differs from the last accepted write count. A wrong offset pointer shows up as a shifted or unwrapped pattern on `cfg_q` right after the write frame, or in the data returned by the next read. Read-only and reject cases are checked by reading the affected registers back over the bus and on `cfg_q` before any further write.

// File: rtl/smbus_index_slave.sv
module smbus_index_slave #(
  parameter int          REG_COUNT = 32,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter logic [7:0]  ID_VALUE  = 8'h15,
  parameter int          ID_REG    = 7,
  parameter int          SEL_REG   = 6,
  parameter int          SEL_BITS  = 3,
  parameter logic [7:0]  CNT_RESET = 8'd8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [SEL_BITS-1:0]    sel_in,
  output logic [REG_COUNT*8-1:0] cfg_q
);
  localparam int         AW       = $clog2(REG_COUNT);
  localparam logic [7:0] WR_BYTE  = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE  = {DEV_ADDR, 1'b1};
  localparam logic [7:0] SEL_MASK = 8'((1 << SEL_BITS) - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} state_t;
  typedef enum logic [2:0] {B_ADDR, B_OFF, B_CNT, B_WDAT, B_RCNT, B_RDAT} role_t;

  state_t      state;
  role_t       role;
  logic [2:0]  scl_p, sda_p;
  logic [3:0]  bitc;
  logic [7:0]  sh, wrem, txrem, rd_cnt, wm_cur;
  logic [AW-1:0] ptr;
  logic        mack, byte_ok;
  logic [7:0]  mem [REG_COUNT];
  logic [7:0]  vw  [REG_COUNT];

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) begin
      vw[i] = mem[i];
      if (i == SEL_REG) vw[i][SEL_BITS-1:0] = sel_in;
      if (i == ID_REG)  vw[i] = ID_VALUE;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_out
    assign cfg_q[g*8 +: 8] = vw[g];
  end

  assign wm_cur = (ptr == AW'(ID_REG))  ? 8'h00 :
                  (ptr == AW'(SEL_REG)) ? ~SEL_MASK : 8'hFF;

  always_comb begin
    case (role)
      B_ADDR:  byte_ok = (sh == WR_BYTE) || (sh == RD_BYTE);
      B_OFF:   byte_ok = 1'b1;
      B_CNT:   byte_ok = (sh != 8'd0);
      B_WDAT:  byte_ok = (wrem != 8'd0);
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      role   <= B_ADDR;
      sda_oe <= 1'b0;
      bitc   <= '0;
      sh     <= '0;
      wrem   <= '0;
      txrem  <= '0;
      rd_cnt <= CNT_RESET;
      ptr    <= '0;
      mack   <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else if (start_c) begin
      state  <= S_RX;
      role   <= B_ADDR;
      bitc   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX:
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_p[1]};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            if (byte_ok) begin
              sda_oe <= 1'b1;
              state  <= S_RACK;
              case (role)
                B_ADDR: role <= sh[0] ? B_RCNT : B_OFF;
                B_OFF: begin
                  ptr  <= sh[AW-1:0];
                  role <= B_CNT;
                end
                B_CNT: begin
                  rd_cnt <= sh;
                  wrem   <= sh;
                  role   <= B_WDAT;
                end
                B_WDAT: begin
                  mem[ptr] <= (mem[ptr] & ~wm_cur) | (sh & wm_cur);
                  ptr      <= ptr + AW'(1);
                  wrem     <= wrem - 8'd1;
                end
                default: ;
              endcase
            end else begin
              state <= S_IDLE;
            end
          end
        S_RACK:
          if (scl_fall) begin
            bitc <= '0;
            if (role == B_RCNT) begin
              sh     <= rd_cnt;
              sda_oe <= ~rd_cnt[7];
              txrem  <= rd_cnt;
              role   <= B_RDAT;
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
        S_TX:
          if (scl_rise) begin
            bitc <= bitc + 4'd1;
          end else if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= S_TACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
            end
          end
        S_TACK:
          if (scl_rise) begin
            mack <= ~sda_p[1];
          end else if (scl_fall) begin
            if (mack && txrem != 8'd0) begin
              sh     <= vw[ptr];
              sda_oe <= ~vw[ptr][7];
              ptr    <= ptr + AW'(1);
              txrem  <= txrem - 8'd1;
              bitc   <= '0;
              state  <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        default: ;
      endcase
    end
  end
endmodule

module smbus_index_slave_chk #(
  parameter int REG_COUNT = 32,
  parameter int ID_REG    = 7,
  parameter int SEL_REG   = 6,
  parameter int SEL_BITS  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_now,
  input logic                   scl_prev,
  input logic                   sda_oe,
  input logic                   idle,
  input logic [3:0]             bitc,
  input logic [7:0]             rd_cnt,
  input logic [REG_COUNT*8-1:0] cfg_q
);
  function automatic logic [REG_COUNT*8-1:0] mk_mask();
    logic [REG_COUNT*8-1:0] m;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (i == ID_REG)       m[i*8 +: 8] = 8'h00;
      else if (i == SEL_REG) m[i*8 +: 8] = ~8'((1 << SEL_BITS) - 1);
      else                   m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction
  localparam logic [REG_COUNT*8-1:0] WMASK = mk_mask();

  p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_now && scl_prev) |-> $stable(sda_oe));

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt != 8'd0);

  p_bits_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitc <= 4'd8);

  p_write_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q & WMASK) |-> $past(!scl_now && scl_prev));
endmodule

bind smbus_index_slave smbus_index_slave_chk #(
  .REG_COUNT(REG_COUNT), .ID_REG(ID_REG), .SEL_REG(SEL_REG), .SEL_BITS(SEL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_now(scl_p[1]), .scl_prev(scl_p[2]),
  .sda_oe(sda_oe), .idle(state == S_IDLE), .bitc(bitc), .rd_cnt(rd_cnt),
  .cfg_q(cfg_q)
);

// File: tb/smbus_index_slave_bench.sv
`timescale 1ns/1ps
module smbus_index_slave_bench;
  localparam int Q = 5;
  localparam logic [7:0] IDV = 8'h15;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda_low = 0;
  logic sda_oe;
  logic [2:0] sel_v = 3'b101;
  logic [255:0] cfg_q;
  wire sda_line = ~(m_sda_low | sda_oe);

  smbus_index_slave u_smbus_index_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .sel_in(sel_v), .cfg_q(cfg_q));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, viol = 0;
  bit done = 0;
  logic [7:0] m_mem [32];
  int m_cnt = 8;
  logic [7:0] wbuf [16];
  logic prev_scl = 1, prev_oe = 0;

  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_oe !== prev_oe) viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view(input int i);
    if (i == 7) return IDV;
    if (i == 6) return {m_mem[6][7:3], sel_v};
    return m_mem[i];
  endfunction

  task automatic wq(input int n); repeat (n * Q) @(negedge clk); endtask

  task automatic send_bit(input bit b);
    wq(1); m_sda_low = ~b; wq(1); m_scl = 1; wq(2); m_scl = 0;
  endtask

  task automatic read_bit(output bit b);
    wq(1); m_sda_low = 0; wq(1); m_scl = 1; wq(1); b = sda_line; wq(1); m_scl = 0;
  endtask

  task automatic bus_start();
    wq(1); m_sda_low = 0; wq(1); m_scl = 1; wq(2); m_sda_low = 1; wq(2); m_scl = 0;
  endtask

  task automatic bus_stop();
    wq(1); m_sda_low = 1; wq(1); m_scl = 1; wq(2); m_sda_low = 0; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit nack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(nack);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    send_bit(nack);
  endtask

  task automatic check_cfg(input string req);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < 32; i++)
      if (cfg_q[i*8 +: 8] !== view(i)) begin ok = 0; bad = i; end
    chk(ok, req, cfg_q[bad*8 +: 8], view(bad));
  endtask

  task automatic wr_frame(input int off, input int n, input int extra, input string req);
    bit nk;
    bus_start();
    send_byte(8'hD2, nk); chk(nk == 0, "R1 write address ack", nk, 0);
    send_byte(8'(off), nk); chk(nk == 0, req, nk, 0);
    send_byte(8'(n), nk); chk(nk == 0, req, nk, 0);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], nk); chk(nk == 0, req, nk, 0);
    end
    for (int k = 0; k < extra; k++) begin
      send_byte(8'hA5, nk); chk(nk == 1, "R4 byte past count not acked", nk, 1);
    end
    bus_stop();
    m_cnt = n;
    for (int k = 0; k < n; k++) begin
      int r = (off + k) % 32;
      if (r == 6) m_mem[6] = {wbuf[k][7:3], m_mem[6][2:0]};
      else if (r != 7) m_mem[r] = wbuf[k];
    end
    check_cfg(req);
  endtask

  task automatic rd_frame(input int off, input int nread, input string req);
    bit nk;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, nk); chk(nk == 0, "R1 address ack", nk, 0);
    send_byte(8'(off), nk); chk(nk == 0, "R5 offset ack", nk, 0);
    bus_start();
    send_byte(8'hD3, nk); chk(nk == 0, "R1 read address ack", nk, 0);
    recv_byte(0, d); chk(d == 8'(m_cnt), "R6 count byte", d, m_cnt);
    for (int k = 0; k < nread; k++) begin
      recv_byte(k == nread - 1, d);
      chk(d == view((off + k) % 32), req, d, view((off + k) % 32));
    end
    bus_stop();
    chk(sda_oe == 0, "R7 released after nack", sda_oe, 0);
  endtask

  initial begin
    bit nk;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R10 released after reset", sda_oe, 0);
    check_cfg("R10 reset register values");

    rd_frame(0, 8, "R5 read after reset");

    bus_start();
    send_byte(8'hA4, nk); chk(nk == 1, "R1 foreign address not acked", nk, 1);
    send_byte(8'h00, nk); chk(nk == 1, "R1 stays released", nk, 1);
    bus_stop();

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(2, 3, 0, "R2 block write");

    bus_start();
    send_byte(8'hD2, nk); send_byte(8'h10, nk);
    send_byte(8'h00, nk); chk(nk == 1, "R3 zero count rejected", nk, 1);
    send_byte(8'h77, nk);
    bus_stop();
    check_cfg("R3 nothing stored");
    rd_frame(2, 3, "R3 count unchanged");

    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_frame(12, 2, 2, "R4 exact count write");
    rd_frame(12, 2, "R4 readback");

    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3; wbuf[3] = 8'hE4;
    wr_frame(30, 4, 0, "R8 wrap write");
    rd_frame(31, 3, "R8 wrap read");

    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    wr_frame(6, 2, 0, "R9 read-only bits");
    chk(cfg_q[63:56] == IDV, "R9 identity byte", cfg_q[63:56], IDV);
    sel_v = 3'b010;
    repeat (3) @(negedge clk);
    check_cfg("R9 select mirror");
    rd_frame(5, 2, "R9 read-only readback");

    rd_frame(0, 1, "R7 early stop");
    rd_frame(1, 1, "R7 next frame after early stop");

    for (int f = 0; f < 16; f++) begin
      int off = $urandom_range(31);
      if ($urandom_range(1)) begin
        int n = $urandom_range(6, 1);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        wr_frame(off, n, 0, "R2 random write");
      end else begin
        rd_frame(off, $urandom_range(m_cnt, 1), "R5 random read");
      end
    end

    chk(viol == 0, "R11 SDA changed while SCL high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule